// File: doc/BRIEF.md
# Strobe-Framed Slot Pipeline Sequencer

This block orders the per-slot work of a serial voice codec core whose slots are framed by an external strobe. Each time the strobe falls, the block samples a direction line. A high level marks the slot as an encode slot, with linear samples in and compressed codes out. A low level marks it as a decode slot. The block then pulses the capture strobe for that path.

The slot's direction tag then moves through three stages. When the strobe falls again, the block pulses a processing start and reports the slot's direction. During the slot period after that, the block raises the output enable that matches the tag, but only while the strobe is high. Three slots are therefore in flight at any time: one being captured, one being processed and one being shifted out.

The strobe and the direction line are both asynchronous to the system clock, so the block synchronises them first. The arithmetic and the shift registers are outside this block. Eight half-duplex slots fit in one 8 kHz frame. Four full-duplex channels also fit, with the direction line alternating from slot to slot.

Top module: `slot_pipe_seq`

## Requirements
- R1: On the third clock edge after `ce_in` goes from high to low, `cap_enc` is high for exactly one cycle if `dir_in` was 1 during the clock after the fall.
- R2: Under the same timing as R1, `cap_dec` pulses for one cycle if `dir_in` was 0 during the clock after the fall.
- R3: When a strobe fall closes a period that held a captured slot, `proc_start` pulses in the same cycle as that fall's capture strobe. In that cycle `proc_dir` is set to the earlier slot's direction (1 = encode) and holds that value until the next such event.
- R4: During the period that follows the processing period, `oe_comp` is high while `ce_in` (delayed by two clocks) is high if the slot was an encode slot. `oe_lin` behaves the same way for a decode slot.
- R5: The asynchronous reset clears all in-flight slots. No output enable rises until three strobe falls have occurred after reset.
- R6: Rising edges of `ce_in`, and changes of `dir_in` away from the sampling cycle, produce no strobe.
- R7: At most one capture strobe is high at a time, and at most one output enable is high at a time.
- R8: When the direction alternates on every slot, the output enables alternate in step with it, two slots behind the captures.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_in | input | 1 | Slot framing strobe, asynchronous |
| dir_in | input | 1 | Slot direction, 1 = encode, asynchronous |
| cap_enc | output | 1 | Capture pulse, encode input path |
| cap_dec | output | 1 | Capture pulse, decode input path |
| proc_start | output | 1 | Processing start pulse |
| proc_dir | output | 1 | Direction of the slot being processed |
| oe_comp | output | 1 | Compressed-code output enable |
| oe_lin | output | 1 | Linear-sample output enable |

## Verification
A corrupted or shifted tag stage appears at the ports within two strobe falls. It shows up as `proc_dir` or an output enable that does not match the direction that was sampled, or as an enable during the wrong period. An error in the edge detector or the synchroniser moves every strobe off the three-clock point, or adds or drops pulses, and this shows on the next strobe edge. The reference model tracks the expected value of every output on every cycle, so a slip of one cycle is caught.

// File: rtl/slot_seq_pkg.sv
package slot_seq_pkg;
  typedef struct packed {
    logic valid;
    logic enc;
  } slot_tag_t;
endpackage

// File: rtl/seq_sync.sv
module seq_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  logic [WIDTH-1:0] chain_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= '0;
          else        chain_q[s] <= d_in;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= '0;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/seq_fall_det.sv
module seq_fall_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic fall
);
  logic lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl;
  end

  assign fall = lvl_q & ~lvl;
endmodule

// File: rtl/seq_tag_pipe.sv
module seq_tag_pipe
  import slot_seq_pkg::*;
#(
  parameter int DEPTH = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  adv,
  input  slot_tag_t             tag_in,
  output slot_tag_t [DEPTH-1:0] tags
);
  slot_tag_t [DEPTH-1:0] tags_q, tags_d;

  always_comb begin
    tags_d = tags_q;
    if (adv) begin
      tags_d[0] = tag_in;
      for (int i = 1; i < DEPTH; i++) tags_d[i] = tags_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tags_q <= '0;
    else        tags_q <= tags_d;
  end

  assign tags = tags_q;
endmodule

// File: rtl/slot_pipe_seq.sv
module slot_pipe_seq
  import slot_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PIPE_DEPTH  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_in,
  input  logic dir_in,
  output logic cap_enc,
  output logic cap_dec,
  output logic proc_start,
  output logic proc_dir,
  output logic oe_comp,
  output logic oe_lin
);
  localparam int PROC_IDX = 1;
  localparam int OUT_IDX  = PIPE_DEPTH - 1;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic [1:0] sync_bus;
  logic       ce_s, dir_s, ce_fall;
  slot_tag_t  new_tag;
  slot_tag_t [PIPE_DEPTH-1:0] tags;

  logic cap_enc_q, cap_dec_q, start_q, pdir_q;
  logic cap_enc_d, cap_dec_d, start_d, pdir_d;

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  seq_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d_in  ({ce_in, dir_in}),
    .d_out (sync_bus)
  );
  assign ce_s  = sync_bus[1];
  assign dir_s = sync_bus[0];

  seq_fall_det u_fall (
    .clk   (clk),
    .rst_n (rst_int_n),
    .lvl   (ce_s),
    .fall  (ce_fall)
  );

  assign new_tag = '{valid: 1'b1, enc: dir_s};

  seq_tag_pipe #(.DEPTH(PIPE_DEPTH)) u_pipe (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .adv    (ce_fall),
    .tag_in (new_tag),
    .tags   (tags)
  );

  always_comb begin
    cap_enc_d = ce_fall & dir_s;
    cap_dec_d = ce_fall & ~dir_s;
    start_d   = ce_fall & tags[PROC_IDX-1].valid;
    pdir_d    = pdir_q;
    if (ce_fall) pdir_d = tags[PROC_IDX-1].enc;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      cap_enc_q <= 1'b0;
      cap_dec_q <= 1'b0;
      start_q   <= 1'b0;
      pdir_q    <= 1'b0;
    end else begin
      cap_enc_q <= cap_enc_d;
      cap_dec_q <= cap_dec_d;
      start_q   <= start_d;
      pdir_q    <= pdir_d;
    end
  end

  assign cap_enc    = cap_enc_q;
  assign cap_dec    = cap_dec_q;
  assign proc_start = start_q;
  assign proc_dir   = pdir_q;
  assign oe_comp    = tags[OUT_IDX].valid & tags[OUT_IDX].enc  & ce_s;
  assign oe_lin     = tags[OUT_IDX].valid & ~tags[OUT_IDX].enc & ce_s;
endmodule

// File: rtl/slot_pipe_seq_chk.sv
module slot_pipe_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic cap_enc,
  input logic cap_dec,
  input logic proc_start,
  input logic oe_comp,
  input logic oe_lin
);
  p_cap_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cap_enc, cap_dec}));
  p_oe_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({oe_comp, oe_lin}));
  p_cap_enc_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cap_enc |=> !cap_enc);
  p_cap_dec_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cap_dec |=> !cap_dec);
  p_start_with_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    proc_start |-> (cap_enc || cap_dec));
  p_no_oe_at_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_enc || cap_dec) |-> !(oe_comp || oe_lin));
endmodule

bind slot_pipe_seq slot_pipe_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cap_enc    (cap_enc),
  .cap_dec    (cap_dec),
  .proc_start (proc_start),
  .oe_comp    (oe_comp),
  .oe_lin     (oe_lin)
);

// File: tb/slot_pipe_seq_tb.sv
module slot_pipe_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYC    = 100000;

  logic clk = 1'b0;
  logic rst_n, ce_in, dir_in;
  logic cap_enc, cap_dec, proc_start, proc_dir, oe_comp, oe_lin;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  int total    = 0;
  bit fd_phase = 1'b0;
  bit done     = 1'b0;

  bit h_ce  [0:16383];
  bit h_dir [0:16383];
  bit tagq  [$];
  bit e_cap_enc, e_cap_dec, e_start, e_pdir, e_oe_comp, e_oe_lin, e_fall;

  always #(CLK_PERIOD/2) clk = ~clk;

  slot_pipe_seq u_dut (
    .clk(clk), .rst_n(rst_n), .ce_in(ce_in), .dir_in(dir_in),
    .cap_enc(cap_enc), .cap_dec(cap_dec), .proc_start(proc_start),
    .proc_dir(proc_dir), .oe_comp(oe_comp), .oe_lin(oe_lin)
  );

  function automatic bit hce(int i);
    return (i < 0) ? 1'b0 : h_ce[i];
  endfunction
  function automatic bit hdir(int i);
    return (i < 0) ? 1'b0 : h_dir[i];
  endfunction

  task automatic check(string tag, string what, bit act, bit exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s at cycle %0d: actual %0b expected %0b", tag, what, cyc, act, exp);
    end
  endtask

  // behavioural reference, updated on each clock
  always @(posedge clk) begin
    total++;
    if (!rst_n) begin
      tagq.delete();
      cyc = 0;
      e_cap_enc = 0; e_cap_dec = 0; e_start = 0; e_pdir = 0;
      e_oe_comp = 0; e_oe_lin = 0; e_fall = 0;
    end else begin
      h_ce[cyc]  = ce_in;
      h_dir[cyc] = dir_in;
      e_fall    = hce(cyc-3) && !hce(cyc-2);
      e_cap_enc = e_fall && hdir(cyc-2);
      e_cap_dec = e_fall && !hdir(cyc-2);
      e_start   = e_fall && (tagq.size() > 0);
      if (e_fall) begin
        e_pdir = (tagq.size() > 0) ? tagq[0] : 1'b0;
        tagq.push_front(hdir(cyc-2));
        if (tagq.size() > 3) void'(tagq.pop_back());
      end
      e_oe_comp = (tagq.size() == 3) && hce(cyc-1) && tagq[2];
      e_oe_lin  = (tagq.size() == 3) && hce(cyc-1) && !tagq[2];
      cyc++;
    end
    #(CLK_PERIOD/4);
    if (!done) begin
      check(e_fall ? "R1" : "R6", "cap_enc", cap_enc, e_cap_enc);
      check(e_fall ? "R2" : "R6", "cap_dec", cap_dec, e_cap_dec);
      check("R3", "proc_start", proc_start, e_start);
      check("R3", "proc_dir", proc_dir, e_pdir);
      check((tagq.size() < 3) ? "R5" : (fd_phase ? "R8" : "R4"), "oe_comp", oe_comp, e_oe_comp);
      check((tagq.size() < 3) ? "R5" : (fd_phase ? "R8" : "R4"), "oe_lin", oe_lin, e_oe_lin);
      check("R7", "exclusive", (cap_enc & cap_dec) | (oe_comp & oe_lin), 1'b0);
    end
  end

  task automatic slot(bit dir, int hi, int lo, bit wiggle);
    @(negedge clk); ce_in = 1'b1; dir_in = ~dir;
    for (int i = 0; i < hi; i++) begin
      @(negedge clk);
      if (wiggle && i < hi - 3) dir_in = ~dir_in;
      else dir_in = dir;
    end
    ce_in = 1'b0;
    for (int i = 0; i < lo; i++) begin
      @(negedge clk);
      if (i >= 2 && wiggle) dir_in = ~dir_in;
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; ce_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; ce_in = 1'b0; dir_in = 1'b0;
    repeat (2) @(negedge clk);
    // R5: reset state of every output
    check("R5", "reset cap", cap_enc | cap_dec, 1'b0);
    check("R5", "reset start", proc_start, 1'b0);
    check("R5", "reset oe", oe_comp | oe_lin, 1'b0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    // R8: full-duplex alternation
    fd_phase = 1'b1;
    for (int k = 0; k < 10; k++) slot(k[0], 10, 4, 1'b0);
    fd_phase = 1'b0;
    // R4: runs of one direction
    for (int k = 0; k < 5; k++) slot(1'b1, 8, 5, 1'b0);
    for (int k = 0; k < 5; k++) slot(1'b0, 8, 5, 1'b0);
    // R6: direction toggling outside the sampling point
    for (int k = 0; k < 12; k++) slot((k % 3) == 0, 12, 8, 1'b1);
    // R5: reset mid-stream clears the pipeline
    do_reset();
    for (int k = 0; k < 6; k++) slot(k[1], 6, 3, 1'b0);
    // short strobes, varied lengths
    for (int k = 0; k < 40; k++) slot(((k * 7) % 5) > 1, 3 + (k % 4), 3 + (k % 3), 1'b0);
    repeat (10) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    wait (total > MAX_CYC);
    if (!done) begin
      done = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule